// File: doc/BRIEF.md
# Periodic Countdown Timer

This block is a programmable down-counter driven by one of several external time-base strobes, such as a one-microsecond tick from a shared prescaler. Software writes a control word that holds the enable flag, the auto-reload flag and the preload value. Each time the selected strobe is high, the counter steps down by one. When the counter is already at zero and a strobe arrives, the timer expires.

On expiry the block latches an interrupt flag, which software clears by writing a one to it. It also produces a single-cycle expiry pulse that a neighbouring watchdog can count as its own tick. In periodic mode the counter then reloads from the preload value and keeps running. In one-shot mode the timer switches itself off.

A separate register chooses which strobe input drives the counter. The strobe generators and the interrupt controller sit outside the block.

Top module: `cdtimer`

## Requirements
- R1: After reset, every readable field is zero. This covers enable, periodic, preload, count, interrupt flag and source select. `irq` and `expire` are low.
- R2: Writing address 0 (control) stores bit 31 as enable, bit 30 as periodic and bits [CNT_W-1:0] as preload. Other bits are discarded. A read of address 0 returns these fields in the same positions. If the write sets bit 31, the count is loaded from the written preload on the same clock edge.
- R3: While the timer is enabled, each cycle in which the selected strobe is high and the count is non-zero lowers the count by one. Cycles without the strobe leave the count unchanged.
- R4: A selected strobe that arrives while enabled with the count at zero is an expiry. On the next edge the interrupt flag is set and `expire` is high for exactly one cycle.
- R5: In periodic mode an expiry reloads the count from preload and the timer stays enabled. Expiries therefore come every preload+1 strobes.
- R6: In one-shot mode an expiry clears enable, and the count remains zero. Later strobes cause no further expiries.
- R7: Writing the control register with bit 31 clear stops the timer. The count then holds its value and no expiry occurs.
- R8: A read of address 1 (status) returns the interrupt flag in bit 30 and the count in bits [CNT_W-1:0], with all other bits zero. A status write with bit 30 set clears the flag. A status write with bit 30 clear leaves the flag alone. If an expiry and a clearing write fall in the same cycle, the flag stays set.
- R9: `irq` always equals the interrupt flag.
- R10: Address 2 (source select) holds a value k that routes `src_tick[k]` to the counter. Value 0, the reset value, picks input 0, the microsecond base. A value of NUM_SRC or more selects no strobe, so the count freezes. The value reads back from address 2.
- R11: With a preload of zero, an enabled timer expires on the first selected strobe.
- R12: If a control write and a selected strobe fall in the same cycle, the write wins. The count takes the written preload, and no decrement or expiry happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 source select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data |
| src_tick | input | NUM_SRC | Time-base strobes, one per selectable source |
| irq | output | 1 | Interrupt, equal to the status flag |
| expire | output | 1 | One-cycle pulse after each expiry |

## Verification
The bench builds the timer with CNT_W = 16 and NUM_SRC = 3. With this width, bits above the preload field inside the 28-bit span can be written and shown to be discarded. Three sources in a two-bit select field leave one code, 3, with no input behind it, so the select-nothing case can be reached. Small preloads keep the periodic spacing, the one-shot stop and the zero-preload expiry within a few strobes.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned PER_BIT = 30;
  localparam int unsigned FLG_BIT = 30;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_SRC  = 2'd2,
    ADR_NONE = 2'd3
  } cdt_addr_e;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/cdt_srcsel.sv
module cdt_srcsel #(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr,
  input  logic [SEL_W-1:0]   sel_wdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [SEL_W-1:0]   sel_q,
  output logic               tick_o
);
  logic [SEL_W-1:0]   sel_d;
  logic [NUM_SRC-1:0] hit_vec;

  always_comb begin
    sel_d = sel_q;
    if (sel_wr) sel_d = sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sel_d;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit_vec[g] = src_tick[g] && (sel_q == SEL_W'(g));
  end

  assign tick_o = |hit_vec;

  // R10: a code with no source behind it never produces a tick
  p_no_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_q) >= NUM_SRC) |-> !tick_o);
endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic              en_q,
  output logic              per_q,
  output logic [CNT_W-1:0]  preload_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              flag_q,
  output logic              exp_q
);
  logic             en_d, per_d, flag_d;
  logic [CNT_W-1:0] preload_d, count_d;
  logic             hit, fire, cfg_ce, cnt_ce;

  assign hit    = en_q && tick && !ctrl_wr;
  assign fire   = hit && (count_q == '0);
  assign cfg_ce = ctrl_wr || fire;
  assign cnt_ce = ctrl_wr || hit;

  always_comb begin
    en_d      = en_q;
    per_d     = per_q;
    preload_d = preload_q;
    count_d   = count_q;
    if (ctrl_wr) begin
      en_d      = wdata[EN_BIT];
      per_d     = wdata[PER_BIT];
      preload_d = wdata[CNT_W-1:0];
      if (wdata[EN_BIT]) count_d = wdata[CNT_W-1:0];
    end else if (fire) begin
      en_d    = per_q;
      count_d = per_q ? preload_q : '0;
    end else if (hit) begin
      count_d = count_q - 1'b1;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (fire)                         flag_d = 1'b1;
    else if (stat_wr && wdata[FLG_BIT]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      per_q     <= 1'b0;
      preload_q <= '0;
    end else if (cfg_ce) begin
      en_q      <= en_d;
      per_q     <= per_d;
      preload_q <= preload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_ce) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      exp_q  <= fire;
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[EN_BIT] |=> count_q == $past(wdata[CNT_W-1:0]));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  p_exp_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> flag_q);
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q && per_q |-> en_q && (count_q == preload_q));
  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q && !per_q |-> !en_q && (count_q == '0));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !ctrl_wr |=> $stable(count_q) && !exp_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && wdata[FLG_BIT] && !fire |=> !flag_q);
  p_wr_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !exp_q);
endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 28,
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [1:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               irq,
  output logic               expire
);
  logic             rst_i_n;
  logic             ctrl_wr, stat_wr, src_wr, tick;
  logic             en_q, per_q, flag_q, exp_q;
  logic [CNT_W-1:0] preload_q, count_q;
  logic [SEL_W-1:0] sel_q;

  assign ctrl_wr = wr_en && (cdt_addr_e'(wr_addr) == ADR_CTRL);
  assign stat_wr = wr_en && (cdt_addr_e'(wr_addr) == ADR_STAT);
  assign src_wr  = wr_en && (cdt_addr_e'(wr_addr) == ADR_SRC);

  cdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cdt_srcsel #(.NUM_SRC(NUM_SRC)) u_src (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .sel_wr    (src_wr),
    .sel_wdata (wr_data[SEL_W-1:0]),
    .src_tick  (src_tick),
    .sel_q     (sel_q),
    .tick_o    (tick)
  );

  cdt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ctrl_wr   (ctrl_wr),
    .stat_wr   (stat_wr),
    .wdata     (wr_data),
    .tick      (tick),
    .en_q      (en_q),
    .per_q     (per_q),
    .preload_q (preload_q),
    .count_q   (count_q),
    .flag_q    (flag_q),
    .exp_q     (exp_q)
  );

  always_comb begin
    rd_data = '0;
    case (cdt_addr_e'(rd_addr))
      ADR_CTRL: begin
        rd_data[EN_BIT]    = en_q;
        rd_data[PER_BIT]   = per_q;
        rd_data[CNT_W-1:0] = preload_q;
      end
      ADR_STAT: begin
        rd_data[FLG_BIT]   = flag_q;
        rd_data[CNT_W-1:0] = count_q;
      end
      ADR_SRC:  rd_data[SEL_W-1:0] = sel_q;
      default:  rd_data = '0;
    endcase
  end

  assign irq    = flag_q;
  assign expire = exp_q;

  // R9: the interrupt line follows the status flag seen through the read port
  p_irq_rd_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cdt_addr_e'(rd_addr) == ADR_STAT) |-> (irq == rd_data[FLG_BIT]));
endmodule

// File: tb/cdtimer_bench.sv
`timescale 1ns/1ps
module cdtimer_bench;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned NUM_SRC = 3;
  localparam int NV = 41;
  // entry: {op, addr, data}; op 0 write, 1 strobe pattern, 2 read and compare
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 2'd0, 32'h8FFF_0003},  // R2 one-shot, preload 3, high bits dropped
    {2'd2, 2'd0, 32'h8000_0003},  // R2
    {2'd2, 2'd1, 32'h0000_0003},  // R2 count loaded
    {2'd1, 2'd0, 32'h0000_0001},  // R3
    {2'd2, 2'd1, 32'h0000_0002},  // R3
    {2'd1, 2'd0, 32'h0000_0002},  // R10 unselected strobe
    {2'd2, 2'd1, 32'h0000_0002},  // R10
    {2'd1, 2'd0, 32'h0000_0001},
    {2'd1, 2'd0, 32'h0000_0001},
    {2'd2, 2'd1, 32'h0000_0000},  // R3
    {2'd1, 2'd0, 32'h0000_0001},  // R4 expiry
    {2'd2, 2'd1, 32'h4000_0000},  // R4 R8
    {2'd2, 2'd0, 32'h0000_0003},  // R6 enable cleared
    {2'd1, 2'd0, 32'h0000_0001},
    {2'd2, 2'd1, 32'h4000_0000},  // R6
    {2'd0, 2'd1, 32'h0000_0000},  // R8 bit 30 clear
    {2'd2, 2'd1, 32'h4000_0000},  // R8
    {2'd0, 2'd1, 32'h4000_0000},  // R8 clear
    {2'd2, 2'd1, 32'h0000_0000},  // R8
    {2'd0, 2'd2, 32'h0000_0001},  // R10
    {2'd2, 2'd2, 32'h0000_0001},  // R10
    {2'd0, 2'd0, 32'hC000_0001},  // R5 periodic, preload 1
    {2'd1, 2'd0, 32'h0000_0002},
    {2'd2, 2'd1, 32'h0000_0000},
    {2'd1, 2'd0, 32'h0000_0002},
    {2'd2, 2'd1, 32'h4000_0001},  // R5 reload
    {2'd1, 2'd0, 32'h0000_0002},
    {2'd2, 2'd1, 32'h4000_0000},  // R5
    {2'd0, 2'd2, 32'h0000_0003},  // R10 no source
    {2'd1, 2'd0, 32'h0000_0007},
    {2'd2, 2'd1, 32'h4000_0000},  // R10 count frozen
    {2'd0, 2'd2, 32'h0000_0002},
    {2'd1, 2'd0, 32'h0000_0004},
    {2'd2, 2'd1, 32'h4000_0001},  // R10 source 2 expiry
    {2'd0, 2'd0, 32'h0000_0000},  // R7 stop
    {2'd2, 2'd0, 32'h0000_0000},  // R7
    {2'd1, 2'd0, 32'h0000_0004},
    {2'd2, 2'd1, 32'h4000_0001},  // R7 held
    {2'd0, 2'd2, 32'h0000_0000},
    {2'd0, 2'd1, 32'h4000_0000},
    {2'd2, 2'd1, 32'h0000_0001}   // R8
  };

  logic               clk, rst_n, wr_en, irq, expire;
  logic [1:0]         wr_addr, rd_addr;
  logic [31:0]        wr_data, rd_data;
  logic [NUM_SRC-1:0] src_tick;
  int checks, errors;

  cdtimer #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_cdtimer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_tick(src_tick), .irq(irq), .expire(expire)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input logic [NUM_SRC-1:0] tk);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; src_tick = tk;
    @(posedge clk);
    #1;
    wr_en = 1'b0; src_tick = '0;
  endtask

  task automatic rdchk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fires, first;
    checks = 0; errors = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; src_tick = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rdchk("R1 ctrl", 2'd0, 32'h0);
    rdchk("R1 status", 2'd1, 32'h0);
    rdchk("R1 srcsel", 2'd2, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 expire", {31'b0, expire}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][35:34])
        2'd0: drive(1'b1, VEC[i][33:32], VEC[i][31:0], '0);
        2'd1: drive(1'b0, 2'd0, 32'h0, VEC[i][NUM_SRC-1:0]);
        default: rdchk($sformatf("vector %0d", i), VEC[i][33:32], VEC[i][31:0]);
      endcase
    end

    // R11 R4 R9: zero preload fires on first strobe, pulse lasts one cycle
    drive(1'b1, 2'd1, 32'h4000_0000, '0);
    drive(1'b1, 2'd0, 32'h8000_0000, '0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);
    drive(1'b0, 2'd0, 32'h0, 3'b001);
    chk("R11 expire on first strobe", {31'b0, expire}, 32'h1);
    chk("R9 irq follows flag", {31'b0, irq}, 32'h1);
    drive(1'b0, 2'd0, 32'h0, '0);
    chk("R4 pulse one cycle", {31'b0, expire}, 32'h0);
    rdchk("R6 one-shot off", 2'd0, 32'h0000_0000);

    // R8: expiry and clearing write in the same cycle, flag stays set
    drive(1'b1, 2'd0, 32'h8000_0000, '0);
    drive(1'b1, 2'd1, 32'h4000_0000, 3'b001);
    chk("R8 set wins", {31'b0, irq}, 32'h1);
    drive(1'b1, 2'd1, 32'h4000_0000, '0);
    chk("R8 cleared", {31'b0, irq}, 32'h0);

    // R12: control write beats a simultaneous strobe
    drive(1'b1, 2'd0, 32'h8000_0005, '0);
    drive(1'b0, 2'd0, 32'h0, 3'b001);
    drive(1'b0, 2'd0, 32'h0, 3'b001);
    rdchk("R3 two strobes", 2'd1, 32'h0000_0003);
    drive(1'b1, 2'd0, 32'h8000_0005, 3'b001);
    rdchk("R12 write wins", 2'd1, 32'h0000_0005);

    // R5: preload 4 gives an expiry every fifth strobe
    drive(1'b1, 2'd0, 32'hC000_0004, '0);
    fires = 0; first = 0;
    for (int t = 1; t <= 12; t++) begin
      drive(1'b0, 2'd0, 32'h0, 3'b001);
      if (expire) begin
        fires++;
        if (first == 0) first = t;
      end
    end
    chk("R5 first expiry strobe", 32'(first), 32'd5);
    chk("R5 expiries in 12 strobes", 32'(fires), 32'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule